// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Controller with Mode Fault

This block is an 8-bit SPI port that can act either as the bus master, generating the serial clock, or as a slave that follows an external clock. A CPU programs it through a small register interface of three byte-wide locations: a control register, a status register holding the completion flag, and a data register that loads the byte to send and returns the byte received. One shift register serves both directions, so a received byte replaces the transmitted one in place.

The control register chooses the role, the serial clock polarity and phase, the bit order, one of four master clock rates, the interrupt enable and the block enable. If the block is configured as master and the select input is pulled low by another device, the block gives up the master role on its own and raises the completion flag, so software notices the conflict. An interrupt request follows the completion flag, gated by the local enable and a global enable input.

Top module: `spi_periph`

## Requirements
- R1: The control register sits at bus address 0, every bit reads back what was written, and it resets to 0x00. Its bit positions from 7 down to 0 are: interrupt enable, block enable, LSB-first, master, clock polarity, clock phase, rate bit 1, rate bit 0. The status register is at address 1 with the completion flag in bit 7 and zeros elsewhere; the data register is at address 2.
- R2: While the block enable bit is 0, no output enable is active, a data write starts no transfer, the serial clock does not toggle and the completion flag stays 0.
- R3: With the LSB-first bit at 1 the least significant bit is sent and received first; with it at 0 the most significant bit goes first.
- R4: In master mode with the block enabled, a data write while idle starts a transfer of exactly eight serial clock cycles; at its end the completion flag is set and address 2 returns the byte shifted in from the data input.
- R5: The serial clock output rests at the level of the clock polarity bit when idle; in master mode the time between its edges is 2, 8, 32 or 64 system clocks for rate codes 0, 1, 2 and 3 (divide by 4, 16, 64, 128).
- R6: With clock phase 0 input data is sampled on the leading clock edge and output data changes on the trailing edge; with clock phase 1 output changes on the leading edge and input is sampled on the trailing edge.
- R7: In slave mode the data output is enabled only while the select input is low; with clock phase 0 the first bit of the loaded byte is on the data output after select falls and before the first clock edge, and eight clock cycles shift in the master's byte.
- R8: If the select input is low while master mode is enabled, the master bit is cleared, the completion flag is set and any transfer stops; master mode returns only when software writes the master bit again.
- R9: The interrupt request is high exactly when the interrupt enable bit, the completion flag and the global interrupt enable input are all 1.
- R10: The completion flag is cleared only by a status register read while it is set followed later by a data register read or write; a data access without that prior status read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address (0 control, 1 status, 2 data) |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for busAddr |
| globalIe | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | Output enable for sckOut |
| mosiIn | input | 1 | Serial data from an external master |
| mosiOut | output | 1 | Serial data driven in master mode |
| mosiOe | output | 1 | Output enable for mosiOut |
| misoIn | input | 1 | Serial data from an external slave |
| misoOut | output | 1 | Serial data driven in slave mode |
| misoOe | output | 1 | Output enable for misoOut |
| ssN | input | 1 | Active-low select input |

## Verification
The hardest situation to reach is a mode fault in the middle of a running master transfer, because the select input passes through a synchronizer and the fault must win over the transfer sequencing and any pending flag clear. The bench starts a master transfer, drives select low a few cycles later while the clock is toggling, and then checks the control readback, the flag and the clock output enable, releases select and confirms that rewriting the master bit restores master mode. Clock phase and bit order are covered by a bench slave model that watches the serial clock, drives its own byte back and measures every half period.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int DATA_W      = 8;
  localparam int EDGES       = 2 * DATA_W;
  localparam int EDGE_W      = $clog2(EDGES);
  localparam int HALF_MAX    = 64;
  localparam int DIV_W       = $clog2(HALF_MAX + 1);
  localparam int SYNC_STAGES = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irqEn;
    logic       enable;
    logic       lsbFirst;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  typedef struct packed {
    logic load;
    logic presetOut;
    logic sample;
    logic shift;
  } strobe_t;

  function automatic logic [DIV_W-1:0] halfPeriod(input logic [1:0] rate);
    case (rate)
      2'd0:    halfPeriod = DIV_W'(2);
      2'd1:    halfPeriod = DIV_W'(8);
      2'd2:    halfPeriod = DIV_W'(32);
      default: halfPeriod = DIV_W'(HALF_MAX);
    endcase
  endfunction
endpackage

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              inBit,
  output logic [DATA_W-1:0] shData,
  output logic              outBit
);
  logic [DATA_W-1:0] shifted;
  logic              headBit;

  always_comb begin
    headBit = lsbFirst ? shData[0] : shData[DATA_W-1];
    if (lsbFirst) shifted = {inBit, shData[DATA_W-1:1]};
    else          shifted = {shData[DATA_W-2:0], inBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shData <= '0;
      outBit <= 1'b0;
    end else if (strb.load) begin
      shData <= loadVal;
      outBit <= lsbFirst ? loadVal[0] : loadVal[DATA_W-1];
    end else begin
      if (strb.presetOut || strb.shift) outBit <= headBit;
      if (strb.sample)                  shData <= shifted;
    end
  end

  // R3: a freshly loaded byte presents its first bit in the chosen order
  p_load_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outBit == (lsbFirst ? shData[0] : shData[DATA_W-1]));

  // R6: sampling and output change never fall on the same edge
  p_edge_split_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sample && strb.shift));
endmodule

// File: rtl/spi_sequencer.sv
module spi_sequencer
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              ssN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output ctrl_t             ctrlQ,
  output logic              spifQ,
  output logic              busyQ,
  output logic              phaseQ,
  output logic              slaveSel,
  output logic              rxInBit,
  output strobe_t           strb
);
  logic [SYNC_STAGES-1:0] ssSyn, sckSyn, mosiSyn;
  logic                   ssPrev, sckPrev, armedQ;
  logic [DIV_W-1:0]       divQ, halfLim;
  logic [EDGE_W-1:0]      edgeQ;

  logic ssLow, ssFall, masterOn, slaveStart, divHit, slvEdge;
  logic edgeEvt, edgeLead, lastEdge, dataWr, dataAcc, statRd, ctrlWr;
  logic load, startM, modeFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssSyn   <= '1;
      sckSyn  <= '0;
      mosiSyn <= '0;
      ssPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      ssSyn   <= {ssSyn[SYNC_STAGES-2:0], ssN};
      sckSyn  <= {sckSyn[SYNC_STAGES-2:0], sckIn};
      mosiSyn <= {mosiSyn[SYNC_STAGES-2:0], mosiIn};
      ssPrev  <= ssSyn[SYNC_STAGES-1];
      sckPrev <= sckSyn[SYNC_STAGES-1];
    end
  end

  always_comb begin
    ssLow      = !ssSyn[SYNC_STAGES-1];
    ssFall     = ssPrev && ssLow;
    masterOn   = ctrlQ.enable && ctrlQ.master;
    slaveSel   = ctrlQ.enable && !ctrlQ.master && ssLow;
    slaveStart = ctrlQ.enable && !ctrlQ.master && ssFall;
    halfLim    = halfPeriod(ctrlQ.rate);
    divHit     = busyQ && masterOn && (divQ == halfLim - DIV_W'(1));
    slvEdge    = busyQ && slaveSel && (sckSyn[SYNC_STAGES-1] != sckPrev);
    edgeEvt    = divHit || slvEdge;
    edgeLead   = masterOn ? !phaseQ : (sckSyn[SYNC_STAGES-1] ^ ctrlQ.cpol);
    lastEdge   = edgeEvt && (edgeQ == EDGE_W'(EDGES - 1));
    ctrlWr     = busWr && (busAddr == ADDR_CTRL);
    dataWr     = busWr && (busAddr == ADDR_DATA);
    dataAcc    = (busWr || busRd) && (busAddr == ADDR_DATA);
    statRd     = busRd && (busAddr == ADDR_STAT);
    load       = dataWr && !busyQ;
    startM     = load && masterOn;
    modeFault  = masterOn && ssLow;
    rxInBit    = ctrlQ.master ? misoIn : mosiSyn[SYNC_STAGES-1];
    strb.load      = load;
    strb.presetOut = slaveStart;
    strb.sample    = edgeEvt && (edgeLead ^ ctrlQ.cpha);
    strb.shift     = edgeEvt && !(edgeLead ^ ctrlQ.cpha);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      spifQ  <= 1'b0;
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
      phaseQ <= 1'b0;
      divQ   <= '0;
      edgeQ  <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrl_t'(busWdata);

      if (!ctrlQ.enable) begin
        busyQ  <= 1'b0;
        phaseQ <= 1'b0;
        divQ   <= '0;
        edgeQ  <= '0;
      end else if (startM || slaveStart) begin
        busyQ  <= 1'b1;
        phaseQ <= 1'b0;
        divQ   <= '0;
        edgeQ  <= '0;
      end else if (busyQ) begin
        if (!ctrlQ.master && !ssLow) begin
          busyQ <= 1'b0;
          edgeQ <= '0;
        end
        if (masterOn) begin
          if (divHit) begin
            divQ   <= '0;
            phaseQ <= !phaseQ;
          end else begin
            divQ <= divQ + DIV_W'(1);
          end
        end
        if (edgeEvt) begin
          edgeQ <= edgeQ + EDGE_W'(1);
          if (lastEdge) begin
            busyQ <= 1'b0;
            edgeQ <= '0;
          end
        end
      end

      if (!spifQ)      armedQ <= 1'b0;
      else if (statRd) armedQ <= 1'b1;
      if (armedQ && dataAcc) begin
        spifQ  <= 1'b0;
        armedQ <= 1'b0;
      end
      if (lastEdge) spifQ <= 1'b1;

      if (modeFault) begin
        ctrlQ.master <= 1'b0;
        spifQ        <= 1'b1;
        busyQ        <= 1'b0;
        phaseQ       <= 1'b0;
        divQ         <= '0;
        edgeQ        <= '0;
      end
    end
  end

  // R8: select low during master mode drops the role and flags completion
  p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> !ctrlQ.master && spifQ && !busyQ);

  // R4: the sixteenth clock edge ends the transfer with the flag set
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    lastEdge |=> spifQ && !busyQ);

  // R2: a disabled block never holds a transfer open
  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.enable |=> !busyQ);

  // R5: the master clock phase is back at rest whenever no transfer runs
  p_idle_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !phaseQ);

  // R10: the flag only falls after an armed data access
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spifQ) |-> $past(armedQ && dataAcc));
endmodule

// File: rtl/spi_periph.sv
module spi_periph
  import spi_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       globalIe,
  output logic       irq,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       mosiIn,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       ssN
);
  ctrl_t             ctrl;
  strobe_t           strb;
  logic              spif, busy, phase, slaveSel, rxInBit, outBit;
  logic [DATA_W-1:0] shData;

  spi_sequencer seq_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .ssN(ssN), .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .ctrlQ(ctrl), .spifQ(spif), .busyQ(busy), .phaseQ(phase), .slaveSel(slaveSel),
    .rxInBit(rxInBit), .strb(strb)
  );

  spi_shifter shf_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirst(ctrl.lsbFirst),
    .loadVal(busWdata), .inBit(rxInBit), .shData(shData), .outBit(outBit)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = ctrl;
      ADDR_STAT: busRdata = {spif, 7'b0};
      ADDR_DATA: busRdata = shData;
      default:   busRdata = '0;
    endcase
    irq     = ctrl.irqEn && spif && globalIe;
    sckOe   = ctrl.enable && ctrl.master;
    mosiOe  = ctrl.enable && ctrl.master;
    misoOe  = slaveSel;
    sckOut  = ctrl.cpol ^ phase;
    mosiOut = outBit;
    misoOut = outBit;
  end

  // R9: a request never stands without a pending completion
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> spif);

  // R5: a driven but idle serial clock sits at the polarity level
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    sckOe && !busy |-> sckOut == ctrl.cpol);
endmodule

// File: tb/spi_periph_tb.sv
`timescale 1ns/1ps
module spi_periph_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic       globalIe = 1'b0, irq;
  logic       sckIn = 1'b0, sckOut, sckOe;
  logic       mosiIn = 1'b0, mosiOut, mosiOe;
  logic       misoIn = 1'b0, misoOut, misoOe;
  logic       ssN = 1'b1;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench slave model state
  bit         mdlOn = 0;
  logic       mCpol, mCpha, mLsb, mdlPrev;
  logic [7:0] slvTx, capByte;
  int         txN, capN, gap, toggles, gapErr, expHalf;

  always #2.5 clk = ~clk;

  spi_periph dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .globalIe(globalIe), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  function automatic logic slvBit(int k);
    return mLsb ? slvTx[k] : slvTx[7-k];
  endfunction

  always @(negedge clk) begin
    if (mdlOn) begin
      gap++;
      if (sckOut !== mdlPrev) begin
        if (toggles > 0 && gap != expHalf) gapErr++;
        gap = 0;
        toggles++;
        if (sckOut != mCpol) begin // leading edge
          if (!mCpha) begin
            if (capN < 8) capByte[mLsb ? capN : 7-capN] = mosiOut;
            capN++;
          end else begin
            if (txN < 8) misoIn = slvBit(txN);
            txN++;
          end
        end else begin // trailing edge
          if (!mCpha) begin
            txN++;
            if (txN < 8) misoIn = slvBit(txN);
          end else begin
            if (capN < 8) capByte[mLsb ? capN : 7-capN] = mosiOut;
            capN++;
          end
        end
        mdlPrev = sckOut;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(2'd0, d); chk("R1 control reset", d, 8'h00);
    busRead(2'd1, d); chk("R1 status reset", d, 8'h00);
    chk("R9 irq after reset", irq, 0);
    chk("R2 sckOe after reset", sckOe, 0);
    chk("R2 misoOe after reset", misoOe, 0);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    busWrite(2'd0, 8'hA5); busRead(2'd0, d); chk("R1 readback A5", d, 8'hA5);
    busWrite(2'd0, 8'h5A); busRead(2'd0, d); chk("R1 readback 5A", d, 8'h5A);
    chk("R5 idle sck with polarity 1", sckOut, 1);
    busWrite(2'd0, 8'h00); busRead(2'd0, d); chk("R1 readback 00", d, 8'h00);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    busWrite(2'd0, 8'h10); // master bit only, block off
    chk("R2 sckOe off", sckOe, 0);
    chk("R2 mosiOe off", mosiOe, 0);
    busWrite(2'd2, 8'h55);
    waitClk(200);
    chk("R2 sck still idle", sckOut, 0);
    busRead(2'd1, d); chk("R2 no completion when off", d, 8'h00);
    busWrite(2'd0, 8'h00);
  endtask

  task automatic runMaster(input logic cpol, input logic cpha, input logic lsb,
                           input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] d;
    int half;
    half = (rate == 0) ? 2 : (rate == 1) ? 8 : (rate == 2) ? 32 : 64;
    busWrite(2'd0, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate});
    mCpol = cpol; mCpha = cpha; mLsb = lsb; slvTx = stx; expHalf = half;
    txN = 0; capN = 0; gap = 0; toggles = 0; gapErr = 0; capByte = '0;
    mdlPrev = cpol;
    misoIn = slvBit(0);
    chk("R5 idle level before start", sckOut, cpol);
    mdlOn = 1;
    busWrite(2'd2, tx);
    waitClk(16 * half + 10);
    mdlOn = 0;
    chk("R4 sixteen clock edges", toggles, 16);
    chk("R5 half period for rate", gapErr, 0);
    chk("R3 R6 byte seen by slave", capByte, tx);
    chk("R5 idle level after end", sckOut, cpol);
    busRead(2'd1, d); chk("R4 completion flag", d, 8'h80);
    busRead(2'd2, d); chk("R3 R6 byte received from slave", d, stx);
    busRead(2'd1, d); chk("R10 flag cleared by status then data", d, 8'h00);
  endtask

  task automatic testSlave();
    logic [7:0] d, got, mByte, sByte;
    mByte = 8'h2D; sByte = 8'hC6;
    busWrite(2'd0, 8'h40); // enabled slave, phase 0, MSB first
    busWrite(2'd2, sByte);
    waitClk(4);
    chk("R7 miso off while deselected", misoOe, 0);
    ssN = 1'b0;
    waitClk(5);
    chk("R7 miso on while selected", misoOe, 1);
    chk("R7 first bit before first edge", misoOut, sByte[7]);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      mosiIn = mByte[7-i];
      waitClk(8);
      got[7-i] = misoOut;
      sckIn = 1'b1;
      waitClk(8);
      sckIn = 1'b0;
    end
    waitClk(8);
    chk("R7 byte sent by slave", got, sByte);
    busRead(2'd1, d); chk("R7 slave completion", d, 8'h80);
    busRead(2'd2, d); chk("R7 byte received by slave", d, mByte);
    ssN = 1'b1;
    waitClk(5);
    chk("R7 miso off after deselect", misoOe, 0);
    busWrite(2'd0, 8'h00);
  endtask

  task automatic testModeFault();
    logic [7:0] d;
    busWrite(2'd0, 8'h51); // enabled master, rate 1
    busWrite(2'd2, 8'h99);
    waitClk(20);
    ssN = 1'b0;
    waitClk(6);
    busRead(2'd0, d); chk("R8 master bit dropped", d, 8'h41);
    chk("R8 clock no longer driven", sckOe, 0);
    busRead(2'd1, d); chk("R8 flag set by fault", d, 8'h80);
    ssN = 1'b1;
    waitClk(6);
    busRead(2'd0, d); chk("R8 master stays off", d, 8'h41);
    busWrite(2'd0, 8'h51);
    busRead(2'd0, d); chk("R8 master restored by write", d, 8'h51);
    chk("R8 clock driven again", sckOe, 1);
    busRead(2'd2, d);
    busRead(2'd1, d); chk("R10 flag cleared after fault", d, 8'h00);
    busWrite(2'd0, 8'h00);
  endtask

  task automatic testIrqAndClear();
    logic [7:0] d;
    globalIe = 1'b0;
    busWrite(2'd0, 8'hD0); // interrupt enable, enabled master, rate 0
    busWrite(2'd2, 8'h3C);
    waitClk(50);
    chk("R9 no irq with global enable low", irq, 0);
    globalIe = 1'b1;
    waitClk(1);
    chk("R9 irq with all enables", irq, 1);
    busRead(2'd2, d);
    waitClk(1);
    chk("R10 data read alone keeps flag", irq, 1);
    busRead(2'd1, d);
    busWrite(2'd0, 8'h50); // interrupt enable off, flag still set
    waitClk(1);
    chk("R9 no irq with local enable low", irq, 0);
    busWrite(2'd0, 8'hD0);
    waitClk(1);
    chk("R9 irq returns with local enable", irq, 1);
    busRead(2'd1, d);
    busRead(2'd2, d);
    waitClk(1);
    chk("R10 status then data clears flag", irq, 0);
    globalIe = 1'b0;
    busWrite(2'd0, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testRegs();
    testDisabled();
    runMaster(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
    runMaster(1'b1, 1'b1, 1'b1, 2'd1, 8'h96, 8'hE1);
    runMaster(1'b0, 1'b1, 1'b0, 2'd0, 8'h4B, 8'hD2);
    runMaster(1'b1, 1'b0, 1'b1, 2'd3, 8'h1E, 8'h87);
    runMaster(1'b0, 1'b0, 1'b1, 2'd2, 8'h01, 8'h80);
    testSlave();
    testModeFault();
    testIrqAndClear();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule